// File: doc/BRIEF.md
# VLIW Register Scoreboard Counters

This block keeps a cycles-until-free count for every architectural register and every long-latency execution resource of a bundle-issue core. It covers three files of 64 entries (general, floating and accumulator), one file of 8 condition entries, and two slots each of integer divide, floating divide and square root. As the instructions of a bundle are modelled, each one posts the latency of its destination registers into a staged value and writes the busy time of any divide or square-root slot it occupies. The bundle end then moves the staged values into the live counters and advances time by the bundle's cycle count.

Source operands are queried during the bundle. The block keeps the largest busy count seen since the current instruction began, and that value is the stall the bundle must take before issue. A separate advance input lets the caller spend that stall, or any other wait, which counts every counter down with saturation at zero. For the floating and accumulator files, pending busy reductions can be posted during an instruction. They are subtracted from the live counts at the bundle end, before the staged latencies are committed.

Top module: `vliw_scoreboard`

## Requirements
- R1: After reset every counter, staged latency and reduction is zero, and `stallCycles` and `needPostWait` are 0.
- R2: A latency post only raises the staged value of its register to the larger of the old staged value and `latCycles`. A staged value is not visible to queries before the bundle end.
- R3: With `latDouble` or `qDouble` set on a general, floating or accumulator index n, register n+1 is covered as well when n is below 63. At n = 63 only register 63 is covered.
- R4: On `bundleEnd`, every register with a nonzero staged value takes that value as its busy count, even when it is lower. A register whose staged value is zero keeps its busy count. All staged values are then cleared.
- R5: An advance of N cycles sets every counter that is less than or equal to N to zero and subtracts N from the rest. `advValid` with `advCycles` above 255 clears every counter. `advValid` is ignored in a cycle that has `bundleEnd`.
- R6: The bundle cycle count is the largest `insnCycles` reported with `insnDone` since the last bundle end, including one reported in the end cycle itself. `bundleEnd` advances time by that amount after the commit.
- R7: `stallCycles` is registered and shows the largest busy count returned by any query from the cycle of the last `insnStart` up to and including the previous cycle. A query issued in the `insnStart` cycle opens the new window. A cycle with `qValid` and `rqValid` low, or with `rqKind` = 3, adds nothing.
- R8: A resource write sets the counter of slot `resSlot` of kind `resKind` (0 integer divide, 1 floating divide, 2 square root, 3 none) directly to `resCycles`, lower values included. Resource counters advance like register counters, and a write takes priority over an advance in the same cycle.
- R9: `needPostWait` is 1 in the same cycle when `resValid` names a floating divide or square-root slot whose counter is nonzero. For integer divide, and for a free slot, it is 0.
- R10: Reductions posted with `adjValid` (`adjAcc` 0 selects the floating file, 1 the accumulator file) keep the largest amount per register. At `bundleEnd` they are subtracted from the busy count with saturation at zero before the staged value is applied. `insnStart` discards them.
- R11: File codes are 0 general, 1 floating, 2 accumulator and 3 condition. A condition index uses only its low 3 bits, and the double flag has no effect on the condition file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insnStart | input | 1 | First cycle of an instruction: opens the stall window and discards reductions |
| insnDone | input | 1 | An instruction of the bundle reports its cycle count |
| insnCycles | input | 8 | Cycle count of the reporting instruction |
| bundleEnd | input | 1 | Commit staged latencies and advance by the bundle cycle count |
| latValid | input | 1 | Latency post valid |
| latFile | input | 2 | Register file of the latency post |
| latIdx | input | 6 | Register index of the latency post |
| latDouble | input | 1 | Latency post also covers index + 1 |
| latCycles | input | 8 | Latency to post |
| adjValid | input | 1 | Busy reduction post valid |
| adjAcc | input | 1 | Reduction targets the accumulator file (else the floating file) |
| adjIdx | input | 6 | Register index of the reduction |
| adjCycles | input | 8 | Reduction amount |
| resValid | input | 1 | Resource write valid |
| resKind | input | 2 | Resource kind |
| resSlot | input | 1 | Resource slot |
| resCycles | input | 8 | Busy cycles written to the slot |
| qValid | input | 1 | Register query valid |
| qFile | input | 2 | Register file of the query |
| qIdx | input | 6 | Register index of the query |
| qDouble | input | 1 | Query also covers index + 1 |
| rqValid | input | 1 | Resource query valid |
| rqKind | input | 2 | Resource kind of the query |
| rqSlot | input | 1 | Resource slot of the query |
| advValid | input | 1 | Advance time outside a bundle end |
| advCycles | input | 16 | Cycles to advance |
| stallCycles | output | 8 | Largest queried busy count in the current window |
| needPostWait | output | 1 | Resource write hits a busy floating divide or square-root slot |

## Verification
The bench goes after the edges where a scoreboard quietly miscounts. A latency post that lowers a larger staged value would release a register early. An advance equal to the count, or a wide advance above 255, would leave 1 or a wrapped value behind if the saturation compare were off by one or truncated. A double post at index 63 that wraps would mark register 0 busy. A reduction applied after the commit instead of before would eat into the new latency, and a bundle count that misses an `insnDone` in the end cycle would under-advance every counter. Random bundles on a few colliding indices are compared cycle by cycle with a bench model of the requirements, for the stall window and for the post-wait flag.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_CNT_W = 8;
  localparam int SB_ADV_W = 16;

  typedef enum logic [1:0] {
    FILE_GR  = 2'd0,
    FILE_FR  = 2'd1,
    FILE_ACC = 2'd2,
    FILE_CC  = 2'd3
  } regFile_e;

  typedef enum logic [1:0] {
    RES_IDIV  = 2'd0,
    RES_FDIV  = 2'd1,
    RES_FSQRT = 2'd2,
    RES_NONE  = 2'd3
  } resKind_e;

  typedef struct packed {
    logic                commit;
    logic                advance;
    logic                clearAdj;
    logic [SB_ADV_W-1:0] advAmt;
  } sbStrobe_t;
endpackage

// File: rtl/sb_entry.sv
module sb_entry
  import sb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                latHit,
  input  logic [SB_CNT_W-1:0] latCycles,
  input  logic                adjHit,
  input  logic [SB_CNT_W-1:0] adjCycles,
  input  sbStrobe_t           st,
  output logic [SB_CNT_W-1:0] busy
);
  logic [SB_CNT_W-1:0] staged, adj, busyN, stagedN, adjN;

  always_comb begin
    busyN = busy;
    if (st.commit) begin
      busyN = (adj >= busyN) ? '0 : busyN - adj;
      if (staged != '0) busyN = staged;
    end
    if (st.advance)
      busyN = (SB_ADV_W'(busyN) <= st.advAmt) ? '0 : busyN - st.advAmt[SB_CNT_W-1:0];
    stagedN = st.commit ? '0 : staged;
    if (latHit && latCycles > stagedN) stagedN = latCycles;
    adjN = st.clearAdj ? '0 : adj;
    if (adjHit && adjCycles > adjN) adjN = adjCycles;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= '0;
      staged <= '0;
      adj    <= '0;
    end else begin
      busy   <= busyN;
      staged <= stagedN;
      adj    <= adjN;
    end
  end
endmodule

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int NUM_REG = 64,
  parameter int NUM_CC  = 8,
  parameter int NUM_RES = 2,
  localparam int IDX_W  = $clog2(NUM_REG),
  localparam int CC_W   = $clog2(NUM_CC),
  localparam int SLOT_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  sbStrobe_t           st,
  input  logic                latValid,
  input  logic [1:0]          latFile,
  input  logic [IDX_W-1:0]    latIdx,
  input  logic                latDouble,
  input  logic [SB_CNT_W-1:0] latCycles,
  input  logic                adjValid,
  input  logic                adjAcc,
  input  logic [IDX_W-1:0]    adjIdx,
  input  logic [SB_CNT_W-1:0] adjCycles,
  input  logic                resValid,
  input  logic [1:0]          resKind,
  input  logic [SLOT_W-1:0]   resSlot,
  input  logic [SB_CNT_W-1:0] resCycles,
  input  logic                qValid,
  input  logic [1:0]          qFile,
  input  logic [IDX_W-1:0]    qIdx,
  input  logic                qDouble,
  input  logic                rqValid,
  input  logic [1:0]          rqKind,
  input  logic [SLOT_W-1:0]   rqSlot,
  output logic [SB_CNT_W-1:0] qMax,
  output logic                needPostWait
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REG - 1);

  logic [SB_CNT_W-1:0] busyArr [0:3][0:NUM_REG-1];
  logic [SB_CNT_W-1:0] resBusy [0:2][0:NUM_RES-1];

  for (genvar f = 0; f < 4; f++) begin : g_file
    for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
      if (f == 3 && i >= NUM_CC) begin : g_none
        assign busyArr[f][i] = '0;
      end else if (f == 3) begin : g_cc
        sb_entry i_entry (
          .clk(clk), .rstN(rstN),
          .latHit(latValid && latFile == 2'(f) && latIdx[CC_W-1:0] == CC_W'(i)),
          .latCycles(latCycles), .adjHit(1'b0), .adjCycles(adjCycles),
          .st(st), .busy(busyArr[f][i]));
      end else begin : g_wide
        sb_entry i_entry (
          .clk(clk), .rstN(rstN),
          .latHit(latValid && latFile == 2'(f) &&
                  (latIdx == IDX_W'(i) ||
                   (latDouble && latIdx != LAST_IDX && latIdx + 1'b1 == IDX_W'(i)))),
          .latCycles(latCycles),
          .adjHit(adjValid && f != 0 && adjAcc == (f == 2) && adjIdx == IDX_W'(i)),
          .adjCycles(adjCycles),
          .st(st), .busy(busyArr[f][i]));
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      for (int s = 0; s < NUM_RES; s++) begin
        if (!rstN)
          resBusy[k][s] <= '0;
        else if (resValid && resKind == 2'(k) && resSlot == SLOT_W'(s))
          resBusy[k][s] <= resCycles;
        else if (st.advance)
          resBusy[k][s] <= (SB_ADV_W'(resBusy[k][s]) <= st.advAmt) ? '0
                           : resBusy[k][s] - st.advAmt[SB_CNT_W-1:0];
      end
    end
  end

  logic [SB_CNT_W-1:0] qa, qb, rv;
  always_comb begin
    qa = '0;
    qb = '0;
    rv = '0;
    if (qValid) begin
      if (qFile == FILE_CC) begin
        qa = busyArr[3][{{(IDX_W-CC_W){1'b0}}, qIdx[CC_W-1:0]}];
      end else begin
        qa = busyArr[qFile][qIdx];
        if (qDouble && qIdx != LAST_IDX) qb = busyArr[qFile][qIdx + 1'b1];
      end
    end
    if (rqValid && rqKind != RES_NONE) rv = resBusy[rqKind][rqSlot];
    qMax = qa;
    if (qb > qMax) qMax = qb;
    if (rv > qMax) qMax = rv;
  end

  assign needPostWait = resValid && (resKind == RES_FDIV || resKind == RES_FSQRT) &&
                        resBusy[resKind][resSlot] != '0;
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                insnStart,
  input  logic                insnDone,
  input  logic [SB_CNT_W-1:0] insnCycles,
  input  logic                bundleEnd,
  input  logic                advValid,
  input  logic [SB_ADV_W-1:0] advCycles,
  input  logic [SB_CNT_W-1:0] qMax,
  output sbStrobe_t           st,
  output logic [SB_CNT_W-1:0] stallCycles
);
  logic [SB_CNT_W-1:0] bundleMax, endAmt, doneCyc;

  assign doneCyc = insnDone ? insnCycles : '0;
  assign endAmt  = (doneCyc > bundleMax) ? doneCyc : bundleMax;

  always_comb begin
    st.commit   = bundleEnd;
    st.advance  = bundleEnd || advValid;
    st.clearAdj = insnStart;
    st.advAmt   = bundleEnd ? SB_ADV_W'(endAmt) : advCycles;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bundleMax   <= '0;
      stallCycles <= '0;
    end else begin
      bundleMax <= bundleEnd ? '0 : endAmt;
      if (insnStart) stallCycles <= qMax;
      else if (qMax > stallCycles) stallCycles <= qMax;
    end
  end
endmodule

// File: rtl/vliw_scoreboard.sv
module vliw_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REG = 64,
  parameter int NUM_CC  = 8,
  parameter int NUM_RES = 2,
  localparam int IDX_W  = $clog2(NUM_REG),
  localparam int SLOT_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                insnStart,
  input  logic                insnDone,
  input  logic [SB_CNT_W-1:0] insnCycles,
  input  logic                bundleEnd,
  input  logic                latValid,
  input  logic [1:0]          latFile,
  input  logic [IDX_W-1:0]    latIdx,
  input  logic                latDouble,
  input  logic [SB_CNT_W-1:0] latCycles,
  input  logic                adjValid,
  input  logic                adjAcc,
  input  logic [IDX_W-1:0]    adjIdx,
  input  logic [SB_CNT_W-1:0] adjCycles,
  input  logic                resValid,
  input  logic [1:0]          resKind,
  input  logic [SLOT_W-1:0]   resSlot,
  input  logic [SB_CNT_W-1:0] resCycles,
  input  logic                qValid,
  input  logic [1:0]          qFile,
  input  logic [IDX_W-1:0]    qIdx,
  input  logic                qDouble,
  input  logic                rqValid,
  input  logic [1:0]          rqKind,
  input  logic [SLOT_W-1:0]   rqSlot,
  input  logic                advValid,
  input  logic [SB_ADV_W-1:0] advCycles,
  output logic [SB_CNT_W-1:0] stallCycles,
  output logic                needPostWait
);
  sbStrobe_t           st;
  logic [SB_CNT_W-1:0] qMax;

  sb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .insnStart(insnStart), .insnDone(insnDone),
    .insnCycles(insnCycles), .bundleEnd(bundleEnd), .advValid(advValid),
    .advCycles(advCycles), .qMax(qMax), .st(st), .stallCycles(stallCycles));

  sb_datapath #(.NUM_REG(NUM_REG), .NUM_CC(NUM_CC), .NUM_RES(NUM_RES)) i_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .latValid(latValid), .latFile(latFile), .latIdx(latIdx), .latDouble(latDouble),
    .latCycles(latCycles), .adjValid(adjValid), .adjAcc(adjAcc), .adjIdx(adjIdx),
    .adjCycles(adjCycles), .resValid(resValid), .resKind(resKind), .resSlot(resSlot),
    .resCycles(resCycles), .qValid(qValid), .qFile(qFile), .qIdx(qIdx),
    .qDouble(qDouble), .rqValid(rqValid), .rqKind(rqKind), .rqSlot(rqSlot),
    .qMax(qMax), .needPostWait(needPostWait));
endmodule

// File: rtl/sb_checker.sv
module sb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        insnStart,
  input logic        qValid,
  input logic        rqValid,
  input logic        resValid,
  input logic [1:0]  resKind,
  input logic        bundleEnd,
  input logic        advValid,
  input logic [15:0] advCycles,
  input logic [7:0]  stallCycles,
  input logic        needPostWait
);
  // R7: without a new instruction the stall window only grows
  a_r7_stall_monotone: assert property (@(posedge clk) disable iff (!rstN)
    !insnStart |=> stallCycles >= $past(stallCycles));

  // R7: no query and no new instruction leaves the stall unchanged
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!insnStart && !qValid && !rqValid) |=> $stable(stallCycles));

  // R9: the post-wait flag needs a floating divide or square-root write
  a_r9_postwait_source: assert property (@(posedge clk) disable iff (!rstN)
    needPostWait |-> (resValid && (resKind == 2'd1 || resKind == 2'd2)));

  // R5: a wide advance frees every resource slot
  a_r5_wide_flush: assert property (@(posedge clk) disable iff (!rstN)
    (advValid && !bundleEnd && advCycles > 16'd255 && !resValid) |=> !needPostWait);
endmodule

bind vliw_scoreboard sb_checker i_sb_checker (
  .clk(clk), .rstN(rstN), .insnStart(insnStart), .qValid(qValid), .rqValid(rqValid),
  .resValid(resValid), .resKind(resKind), .bundleEnd(bundleEnd), .advValid(advValid),
  .advCycles(advCycles), .stallCycles(stallCycles), .needPostWait(needPostWait));

// File: tb/test_vliw_scoreboard.sv
module test_vliw_scoreboard;
  logic clk = 0;
  logic rstN = 0;
  always #10 clk = ~clk;

  logic insnStart, insnDone, bundleEnd, latValid, latDouble, adjValid, adjAcc;
  logic resValid, resSlot, qValid, qDouble, rqValid, rqSlot, advValid;
  logic [7:0] insnCycles, latCycles, adjCycles, resCycles;
  logic [1:0] latFile, resKind, qFile, rqKind;
  logic [5:0] latIdx, adjIdx, qIdx;
  logic [15:0] advCycles;
  logic [7:0] stallCycles;
  logic needPostWait;

  vliw_scoreboard i_vliw_scoreboard (.*);

  int nChk = 0, nBad = 0;
  bit finished = 0;
  int mBusy[4][64], mStg[4][64], mAdj[4][64], mRes[3][2];
  int mBundle = 0, mWait = 0;

  task automatic chk(string tag, int got, int exp);
    nChk++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clrIn();
    insnStart = 0; insnDone = 0; insnCycles = 0; bundleEnd = 0;
    latValid = 0; latFile = 0; latIdx = 0; latDouble = 0; latCycles = 0;
    adjValid = 0; adjAcc = 0; adjIdx = 0; adjCycles = 0;
    resValid = 0; resKind = 0; resSlot = 0; resCycles = 0;
    qValid = 0; qFile = 0; qIdx = 0; qDouble = 0;
    rqValid = 0; rqKind = 0; rqSlot = 0; advValid = 0; advCycles = 0;
  endtask

  function automatic bit latHitB(int f, int i);
    if (!latValid || int'(latFile) != f) return 0;
    if (f == 3) return (int'(latIdx) % 8) == i;
    return int'(latIdx) == i || (latDouble && latIdx < 63 && int'(latIdx) + 1 == i);
  endfunction

  function automatic int qModel();
    int v = 0;
    if (qValid) begin
      if (qFile == 3) v = mBusy[3][int'(qIdx) % 8];
      else begin
        v = mBusy[qFile][qIdx];
        if (qDouble && qIdx < 63 && mBusy[qFile][qIdx + 1] > v) v = mBusy[qFile][qIdx + 1];
      end
    end
    if (rqValid && rqKind != 3 && mRes[rqKind][rqSlot] > v) v = mRes[rqKind][rqSlot];
    return v;
  endfunction

  // one clock: inputs already driven at the falling edge
  task automatic step();
    int tot, amt, b, s, a;
    bit adv, expNpw;
    #1;
    expNpw = resValid && (resKind == 1 || resKind == 2) && mRes[resKind][resSlot] != 0;
    chk("R9 post-wait flag", needPostWait, expNpw);
    tot = qModel();
    adv = bundleEnd || advValid;
    amt = bundleEnd ? ((insnDone && insnCycles > mBundle) ? insnCycles : mBundle) : advCycles;
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < ((f == 3) ? 8 : 64); i++) begin
        b = mBusy[f][i];
        if (bundleEnd) begin
          b = (mAdj[f][i] >= b) ? 0 : b - mAdj[f][i];
          if (mStg[f][i] != 0) b = mStg[f][i];
        end
        if (adv) b = (b <= amt) ? 0 : b - amt;
        s = bundleEnd ? 0 : mStg[f][i];
        if (latHitB(f, i) && latCycles > s) s = latCycles;
        a = insnStart ? 0 : mAdj[f][i];
        if (adjValid && ((f == 1 && !adjAcc) || (f == 2 && adjAcc)) && adjIdx == i && adjCycles > a)
          a = adjCycles;
        mBusy[f][i] = b; mStg[f][i] = s; mAdj[f][i] = a;
      end
    end
    for (int k = 0; k < 3; k++)
      for (int t = 0; t < 2; t++) begin
        if (resValid && resKind == k && resSlot == t) mRes[k][t] = resCycles;
        else if (adv) mRes[k][t] = (mRes[k][t] <= amt) ? 0 : mRes[k][t] - amt;
      end
    if (bundleEnd) mBundle = 0;
    else if (insnDone && insnCycles > mBundle) mBundle = insnCycles;
    mWait = insnStart ? tot : ((tot > mWait) ? tot : mWait);
    @(posedge clk);
    @(negedge clk);
    chk("R7 stall window", stallCycles, mWait);
    clrIn();
  endtask

  task automatic lat(int f, int idx, bit dbl, int c);
    latValid = 1; latFile = 2'(f); latIdx = 6'(idx); latDouble = dbl; latCycles = 8'(c);
    step();
  endtask

  task automatic endB(int doneCyc);
    bundleEnd = 1; insnDone = doneCyc != 0; insnCycles = 8'(doneCyc);
    step();
  endtask

  task automatic done(int c);
    insnDone = 1; insnCycles = 8'(c);
    step();
  endtask

  task automatic adv(int n);
    advValid = 1; advCycles = 16'(n);
    step();
  endtask

  task automatic adj(bit acc, int idx, int c);
    adjValid = 1; adjAcc = acc; adjIdx = 6'(idx); adjCycles = 8'(c);
    step();
  endtask

  task automatic readBusy(int f, int idx, bit dbl, int exp, string tag);
    insnStart = 1; qValid = 1; qFile = 2'(f); qIdx = 6'(idx); qDouble = dbl;
    step();
    chk(tag, stallCycles, exp);
  endtask

  task automatic readRes(int k, int sl, int exp, string tag);
    insnStart = 1; rqValid = 1; rqKind = 2'(k); rqSlot = sl[0];
    step();
    chk(tag, stallCycles, exp);
  endtask

  task automatic resPw(int k, int sl, int c, int expNpw, string tag);
    resValid = 1; resKind = 2'(k); resSlot = sl[0]; resCycles = 8'(c);
    #1 chk(tag, needPostWait, expNpw);
    step();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    foreach (mBusy[f, i]) begin mBusy[f][i] = 0; mStg[f][i] = 0; mAdj[f][i] = 0; end
    foreach (mRes[k, t]) mRes[k][t] = 0;
    clrIn();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    chk("R1 reset stall", stallCycles, 0);
    chk("R1 reset post-wait", needPostWait, 0);
    readBusy(0, 5, 0, 0, "R1 counter after reset");

    // R2 staged max-merge
    lat(0, 5, 0, 10); lat(0, 5, 0, 4);
    readBusy(0, 5, 0, 0, "R2 staged hidden before end");
    endB(0);
    readBusy(0, 5, 0, 10, "R2 max kept");
    // R4 commit replaces, zero staged keeps
    lat(0, 5, 0, 3); endB(0);
    readBusy(0, 5, 0, 3, "R4 lower staged replaces");
    endB(0);
    readBusy(0, 5, 0, 3, "R4 zero staged keeps");
    // R5 saturating advance
    adv(2);
    readBusy(0, 5, 0, 1, "R5 subtract");
    adv(1);
    readBusy(0, 5, 0, 0, "R5 equal clears");
    lat(0, 5, 0, 20); endB(0); adv(300);
    readBusy(0, 5, 0, 0, "R5 wide clears");
    // R3 double coverage
    lat(1, 63, 1, 7); lat(1, 10, 1, 5); endB(0);
    readBusy(1, 63, 0, 7, "R3 top index");
    readBusy(1, 0, 0, 0, "R3 no wrap");
    readBusy(1, 11, 0, 5, "R3 pair upper");
    readBusy(1, 12, 0, 0, "R3 pair bound");
    readBusy(1, 9, 1, 5, "R3 double query");
    // R6 bundle cycle count
    lat(0, 1, 0, 20); done(3); done(6); endB(4);
    readBusy(0, 1, 0, 14, "R6 advance by max");
    readBusy(1, 63, 0, 1, "R6 other counters advanced");
    // R11 condition file
    lat(3, 10, 1, 6); endB(0);
    readBusy(3, 2, 0, 6, "R11 masked index");
    readBusy(3, 3, 0, 0, "R11 double ignored");
    readBusy(0, 2, 0, 0, "R11 general untouched");
    // R10 reductions
    lat(1, 10, 0, 5); endB(0);
    adj(0, 10, 3); adj(0, 10, 2); endB(0);
    readBusy(1, 10, 0, 2, "R10 max reduction subtracted");
    lat(1, 20, 0, 8); endB(0);
    adj(0, 20, 6); lat(1, 20, 0, 4); endB(0);
    readBusy(1, 20, 0, 4, "R10 staged after reduction");
    lat(2, 2, 0, 9); endB(0);
    adj(1, 2, 4);
    insnStart = 1; step();
    endB(0);
    readBusy(2, 2, 0, 9, "R10 discarded at insnStart");
    // R8 resources
    resPw(0, 1, 9, 0, "R9 idiv free");
    readRes(0, 1, 9, "R8 direct write");
    resPw(0, 1, 2, 0, "R9 idiv busy never");
    readRes(0, 1, 2, "R8 lower write");
    adv(1);
    readRes(0, 1, 1, "R8 advance");
    // R9 post wait
    resPw(1, 0, 5, 0, "R9 free slot");
    resPw(1, 0, 5, 1, "R9 busy fdiv");
    resPw(2, 1, 4, 0, "R9 free fsqrt");
    resPw(2, 1, 4, 1, "R9 busy fsqrt");
    // R7 stall window
    lat(0, 40, 0, 9); lat(0, 41, 0, 3); endB(0);
    insnStart = 1; qValid = 1; qIdx = 41; step();
    chk("R7 window opens", stallCycles, 3);
    qValid = 1; qIdx = 40; step();
    chk("R7 max grows", stallCycles, 9);
    qValid = 1; qIdx = 41; step();
    chk("R7 max held", stallCycles, 9);
    rqValid = 1; rqKind = 3; step();
    chk("R7 kind none adds nothing", stallCycles, 9);
    insnStart = 1; step();
    chk("R7 cleared by insnStart", stallCycles, 0);

    // random bundles on colliding indices
    for (int n = 0; n < 800; n++) begin
      insnStart = ($urandom % 4) == 0;
      insnDone = ($urandom % 3) == 0; insnCycles = 8'($urandom % 12);
      bundleEnd = ($urandom % 6) == 0;
      advValid = !bundleEnd && ($urandom % 10) == 0;
      advCycles = (($urandom % 8) == 0) ? 16'(256 + $urandom % 100) : 16'($urandom % 10);
      latValid = $urandom % 2; latFile = 2'($urandom);
      latIdx = ($urandom % 2) ? 6'($urandom % 8) : 6'(56 + $urandom % 8);
      latDouble = $urandom % 2; latCycles = 8'($urandom % 30);
      adjValid = ($urandom % 3) == 0; adjAcc = $urandom % 2;
      adjIdx = 6'($urandom % 8); adjCycles = 8'($urandom % 10);
      resValid = ($urandom % 4) == 0; resKind = 2'($urandom); resSlot = $urandom % 2;
      resCycles = 8'($urandom % 20);
      qValid = $urandom % 2; qFile = 2'($urandom);
      qIdx = ($urandom % 2) ? 6'($urandom % 8) : 6'(56 + $urandom % 8);
      qDouble = $urandom % 2;
      rqValid = ($urandom % 3) == 0; rqKind = 2'($urandom); rqSlot = $urandom % 2;
      step();
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule